// File: doc/BRIEF.md
# Shared GPIO Port with PWM Input Takeover

This block is a 7-pin general-purpose I/O port. Three registers drive it over a simple register bus: a data register, a direction register and a read-only register that shows the live pins. Every pin can also serve a PWM controller as an input. The four low pins are its fault inputs and the three high pins are its current-sense inputs. The PWM side claims a pin by raising that pin's enable strobe.

When the PWM side enables a function on a pin, it owns that pin. The port then stops driving the pad, whatever the direction bit holds, so the pin is an input. Pad inputs pass through a two-flop synchronizer. The synchronized levels feed the register read paths, the four fault outputs and the three current-sense outputs. Because the synchronizer has no reset, the pin-input register keeps showing the pins while reset is held.

The register map is: address 0 is data, address 1 is direction, address 2 is the pin-input register, and address 3 is unmapped. Bit 7 of every register reads as 0. Writes take effect on the rising clock edge while `bus_we_i` is high. Read data is combinational from `bus_addr_i`.

Top module: `gpio_pwm_port`

## Requirements
- R1: While reset is asserted, the data and direction registers clear to 0 and every pad output enable is 0. The pin-input register still shows the synchronized pins during reset.
- R2: For each pin, `pad_oe_o` is the direction bit (1 = output) AND NOT the pin's peripheral enable. `pad_out_o` carries the stored data bits.
- R3: A fault enable `fault_en_i[k]` forces pin k (k = 0..3) to input, even when its direction bit is 1.
- R4: A current-sense enable `cs_en_i[k]` forces pin 4+k (k = 0..2) to input, even when its direction bit is 1.
- R5: A read of address 0 returns, per pin, the stored data bit when the direction bit is 1 and the synchronized pin level when it is 0. Bit 7 reads as 0.
- R6: A read of address 2 returns the synchronized pin levels whatever the direction bits hold. Writes to address 2 change no register. Bit 7 reads as 0.
- R7: `fault_o` equals synchronized pins 3..0, and `cs_o` equals synchronized pins 6..4 (pin 4 drives bit 0).
- R8: A write to address 0 updates the stored bits even while the pins are inputs or owned by the PWM side. The written value drives the pads once output mode is restored.
- R9: The direction register is 7 bits wide and may be read and written at any time. Bit 7 of a write is dropped and reads back as 0.
- R10: A pad level change becomes visible on `fault_o`, `cs_o` and the read paths after exactly two rising clock edges, not one.
- R11: Address 3 reads as 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 2 | Register address |
| bus_we_i | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i |
| fault_en_i | input | 4 | PWM fault-function enables for pins 3..0 |
| cs_en_i | input | 3 | PWM current-sense enables for pins 6..4 |
| pad_in_i | input | 7 | Pad input levels (asynchronous) |
| pad_oe_o | output | 7 | Per-pin pad output enable |
| pad_out_o | output | 7 | Per-pin pad output data |
| fault_o | output | 4 | Synchronized fault inputs to the PWM |
| cs_o | output | 3 | Synchronized current-sense inputs to the PWM |

## Verification
The hardest case to reach from the ports is a data write that lands while a pin is both an input and owned by the PWM side. In that state the stored bit cannot be seen on a read or on the pad. The bench writes under a peripheral enable with the direction bit cleared. It then drops the enable and sets the direction bit, and only then checks that the earlier value reaches `pad_out_o` and the data read. The bench also holds reset low while the pads carry a pattern, to show that the pin-input register still tracks the pins.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned BUS_W  = 8;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_DATA = 2'd0,
    REG_DIR  = 2'd1,
    REG_PIN  = 2'd2,
    REG_NONE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH  = 7,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  // no reset: pin view must stay live through reset
  always_ff @(posedge clk_i) stage_q[0] <= d_i;

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i) stage_q[s] <= stage_q[s-1];
  end

  assign q_o = stage_q[STAGES-1];

  // R10
  sync_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_o == $past(d_i, STAGES));
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned PORT_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  input  logic [PORT_W-1:0] pin_s_i,
  output logic [PORT_W-1:0] data_q_o,
  output logic [PORT_W-1:0] dir_q_o
);
  localparam int unsigned PAD_W = BUS_W - PORT_W;

  logic [PORT_W-1:0] data_q, dir_q, data_view;
  logic              wr_data, wr_dir;
  logic              unused_wbits;

  assign unused_wbits = ^wdata_i[BUS_W-1:PORT_W];
  assign wr_data = we_i && (addr_i == REG_DATA);
  assign wr_dir  = we_i && (addr_i == REG_DIR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      dir_q  <= '0;
    end else begin
      if (wr_data) data_q <= wdata_i[PORT_W-1:0];
      if (wr_dir)  dir_q  <= wdata_i[PORT_W-1:0];
    end
  end

  for (genvar i = 0; i < PORT_W; i++) begin : g_view
    assign data_view[i] = dir_q[i] ? data_q[i] : pin_s_i[i];
  end

  always_comb begin
    unique case (addr_i)
      REG_DATA: rdata_o = {{PAD_W{1'b0}}, data_view};
      REG_DIR:  rdata_o = {{PAD_W{1'b0}}, dir_q};
      REG_PIN:  rdata_o = {{PAD_W{1'b0}}, pin_s_i};
      default:  rdata_o = '0;
    endcase
  end

  assign data_q_o = data_q;
  assign dir_q_o  = dir_q;

  // R8
  data_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_DATA) |=> data_q == $past(wdata_i[PORT_W-1:0]));
  // R9
  dir_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_DIR) |=> dir_q == $past(wdata_i[PORT_W-1:0]));
  // R6
  pin_wr_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_PIN) |=> $stable(data_q) && $stable(dir_q));
  // R11
  none_wr_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_NONE) |=> $stable(data_q) && $stable(dir_q));
endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl #(
  parameter int unsigned N_FAULT = 4,
  parameter int unsigned N_CS    = 3,
  localparam int unsigned PORT_W = N_FAULT + N_CS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PORT_W-1:0]  data_q_i,
  input  logic [PORT_W-1:0]  dir_q_i,
  input  logic [N_FAULT-1:0] fault_en_i,
  input  logic [N_CS-1:0]    cs_en_i,
  input  logic [PORT_W-1:0]  pin_s_i,
  output logic [PORT_W-1:0]  pad_oe_o,
  output logic [PORT_W-1:0]  pad_out_o,
  output logic [N_FAULT-1:0] fault_o,
  output logic [N_CS-1:0]    cs_o
);
  logic [PORT_W-1:0] periph_own;

  assign periph_own = {cs_en_i, fault_en_i};

  // peripheral ownership beats the direction bit
  for (genvar i = 0; i < PORT_W; i++) begin : g_pin
    assign pad_oe_o[i]  = dir_q_i[i] & ~periph_own[i];
    assign pad_out_o[i] = data_q_i[i];
  end

  assign fault_o = pin_s_i[N_FAULT-1:0];
  assign cs_o    = pin_s_i[PORT_W-1:N_FAULT];

  // R3
  fault_forces_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o[N_FAULT-1:0] & fault_en_i) == '0);
  // R4
  cs_forces_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o[PORT_W-1:N_FAULT] & cs_en_i) == '0);
endmodule

// File: rtl/gpio_pwm_port.sv
module gpio_pwm_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned N_FAULT     = 4,
  parameter int unsigned N_CS        = 3,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned PORT_W     = N_FAULT + N_CS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic               bus_we_i,
  input  logic [BUS_W-1:0]   bus_wdata_i,
  output logic [BUS_W-1:0]   bus_rdata_o,
  input  logic [N_FAULT-1:0] fault_en_i,
  input  logic [N_CS-1:0]    cs_en_i,
  input  logic [PORT_W-1:0]  pad_in_i,
  output logic [PORT_W-1:0]  pad_oe_o,
  output logic [PORT_W-1:0]  pad_out_o,
  output logic [N_FAULT-1:0] fault_o,
  output logic [N_CS-1:0]    cs_o
);
  logic [PORT_W-1:0] pin_s, data_q, dir_q;

  gpio_in_sync #(.WIDTH(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_in_i),
    .q_o   (pin_s)
  );

  gpio_port_regs #(.PORT_W(PORT_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (bus_addr_i),
    .we_i    (bus_we_i),
    .wdata_i (bus_wdata_i),
    .rdata_o (bus_rdata_o),
    .pin_s_i (pin_s),
    .data_q_o(data_q),
    .dir_q_o (dir_q)
  );

  gpio_pin_ctrl #(.N_FAULT(N_FAULT), .N_CS(N_CS)) u_pins (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .data_q_i  (data_q),
    .dir_q_i   (dir_q),
    .fault_en_i(fault_en_i),
    .cs_en_i   (cs_en_i),
    .pin_s_i   (pin_s),
    .pad_oe_o  (pad_oe_o),
    .pad_out_o (pad_out_o),
    .fault_o   (fault_o),
    .cs_o      (cs_o)
  );

  // R7
  fault_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o == $past(pad_in_i[N_FAULT-1:0], SYNC_STAGES));
  // R7
  cs_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_o == $past(pad_in_i[PORT_W-1:N_FAULT], SYNC_STAGES));
  // R1
  reset_oe_chk: assert property (@(posedge clk_i)
    !rst_ni |-> pad_oe_o == '0);
endmodule

// File: tb/gpio_pwm_port_tb.sv
`timescale 1ns/1ps
module gpio_pwm_port_tb;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [1:0] addr = 0;
  logic       we = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic [3:0] fault_en = 0;
  logic [2:0] cs_en = 0;
  logic [6:0] pad_in = 0;
  logic [6:0] pad_oe, pad_out;
  logic [3:0] fault;
  logic [2:0] cs;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  gpio_pwm_port u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_we_i(we),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .fault_en_i(fault_en),
    .cs_en_i(cs_en), .pad_in_i(pad_in), .pad_oe_o(pad_oe),
    .pad_out_o(pad_out), .fault_o(fault), .cs_o(cs)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #0.5; d = rdata;
  endtask

  task automatic set_pads(input logic [6:0] p);
    @(negedge clk); pad_in = p;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    set_pads(7'h3C);
    @(negedge clk); rst_n = 0;
    #1;
    chk("R1 oe in reset", {1'b0, pad_oe}, 8'h00);
    rd(2'd1, d); chk("R1 dir in reset", d, 8'h00);
    rd(2'd2, d); chk("R1 pin reg in reset", d, 8'h3C);
    @(negedge clk); rst_n = 1;
    wr(2'd1, 8'h7F);
    rd(2'd0, d); chk("R1 data reset value", d, 8'h00);
    wr(2'd1, 8'h00);
  endtask

  task automatic t_output();
    logic [7:0] d;
    set_pads(7'h2A);
    wr(2'd1, 8'h7F); wr(2'd0, 8'h55);
    chk("R2 oe", {1'b0, pad_oe}, 8'h7F);
    chk("R2 out", {1'b0, pad_out}, 8'h55);
    rd(2'd0, d); chk("R5 data read output", d, 8'h55);
    wr(2'd1, 8'h0F);
    rd(2'd0, d); chk("R5 data read mixed", d, 8'h25);
    chk("R2 oe partial", {1'b0, pad_oe}, 8'h0F);
  endtask

  task automatic t_input();
    logic [7:0] d;
    wr(2'd1, 8'h00);
    set_pads(7'h33);
    rd(2'd0, d); chk("R5 data read input", d, 8'h33);
    set_pads(7'h7F);
    rd(2'd0, d); chk("R5 bit7 zero", d, 8'h7F);
    wr(2'd1, 8'h7F);
    set_pads(7'h6B);
    rd(2'd2, d); chk("R6 pin reg with outputs", d, 8'h6B);
  endtask

  task automatic t_force();
    wr(2'd1, 8'h7F);
    @(negedge clk); fault_en = 4'b0101; #0.5;
    chk("R3 fault forces input", {1'b0, pad_oe}, 8'h7A);
    @(negedge clk); cs_en = 3'b110; #0.5;
    chk("R4 cs forces input", {1'b0, pad_oe}, 8'h1A);
    @(negedge clk); fault_en = 0; cs_en = 0; #0.5;
    chk("R2 release restores oe", {1'b0, pad_oe}, 8'h7F);
  endtask

  task automatic t_route();
    set_pads(7'h00);
    @(negedge clk); pad_in = 7'h5A;
    @(negedge clk);
    chk("R10 one edge fault old", {4'h0, fault}, 8'h00);
    chk("R10 one edge cs old", {5'h0, cs}, 8'h00);
    @(negedge clk);
    chk("R7 fault route", {4'h0, fault}, 8'h0A);
    chk("R7 cs route", {5'h0, cs}, 8'h05);
  endtask

  task automatic t_hidden_write();
    logic [7:0] d;
    set_pads(7'h00);
    wr(2'd1, 8'h00);
    @(negedge clk); fault_en = 4'hF; cs_en = 3'h7;
    wr(2'd0, 8'h2C);
    rd(2'd0, d); chk("R8 hidden read shows pins", d, 8'h00);
    chk("R8 hidden oe off", {1'b0, pad_oe}, 8'h00);
    @(negedge clk); fault_en = 0; cs_en = 0;
    wr(2'd1, 8'h7F);
    rd(2'd0, d); chk("R8 restored read", d, 8'h2C);
    chk("R8 restored pad", {1'b0, pad_out}, 8'h2C);
  endtask

  task automatic t_pin_write();
    logic [7:0] d;
    set_pads(7'h11);
    wr(2'd2, 8'hFF);
    rd(2'd2, d); chk("R6 pin reg after write", d, 8'h11);
    rd(2'd1, d); chk("R6 dir untouched", d, 8'h7F);
    rd(2'd0, d); chk("R6 data untouched", d, 8'h2C);
  endtask

  task automatic t_dir_rw();
    logic [7:0] d;
    wr(2'd1, 8'hFF);
    rd(2'd1, d); chk("R9 dir bit7 dropped", d, 8'h7F);
    wr(2'd1, 8'h45);
    rd(2'd1, d); chk("R9 dir pattern", d, 8'h45);
    chk("R9 dir drives oe", {1'b0, pad_oe}, 8'h45);
  endtask

  task automatic t_unmapped();
    logic [7:0] d;
    wr(2'd3, 8'hFF);
    rd(2'd3, d); chk("R11 unmapped reads 0", d, 8'h00);
    rd(2'd1, d); chk("R11 dir untouched", d, 8'h45);
    wr(2'd1, 8'h7F);
    rd(2'd0, d); chk("R11 data untouched", d, 8'h2C);
  endtask

  initial begin
    #10000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_output();
    t_input();
    t_force();
    t_route();
    t_hidden_write();
    t_pin_write();
    t_dir_rw();
    t_unmapped();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule